// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is the device-side status logic of a parallel NOR-style flash. A start pulse launches either a byte program (address plus data) or a sector erase (a mask of sectors to erase plus a mask of protected sectors). The internal algorithm is modelled by a busy counter of programmable length. While it runs, reads at the targeted location return a status byte instead of array data, and an active-low ready/busy output is held low. The sector index is the top `SECT_W` bits of the byte address.

Bit 7 of the status byte is the polling bit. During a program it is the inverse of bit 7 of the byte being written. During an erase it reads 0. In erase suspend it reads 1. Bit 6 is a toggle stub, and bits 5:0 read zero. An operation that only touches protected sectors runs for a fixed timeout and leaves the array unchanged. An erase can be suspended, a byte can be programmed while it is suspended, and the erase can then be resumed. At completion, bit 7 shows true data one read before the lower bits do.

Top module: `pe_status_resp`

## Requirements
- R1: After reset, `ready_n` is 1, `rd_valid` is 0 and every array byte reads 0xFF.
- R2: An accepted program drives `ready_n` low from the cycle after the start pulse for exactly `PROG_CYCLES` cycles; afterwards the byte at the program address holds the programmed data.
- R3: While a program runs, a read at the program address returns `{~data[7], t, 6'b0}`, where `t` is the toggle stub.
- R4: While busy, a read at an address that is neither the program address nor inside an erase-selected sector returns array data.
- R5: After an operation ends, the first read at its target (the program address, or any erase-selected sector) returns `{array[7], t, 6'b0}` without flipping `t`; later reads return the full array byte.
- R6: A program whose sector is protected stays busy for `PROT_PROG_CYCLES` cycles, shows the R3 status, and leaves the array unchanged.
- R7: While an erase runs, reads in selected sectors return `{1'b0, t, 6'b0}`; after `ERASE_CYCLES` busy cycles, selected unprotected sectors read 0xFF and all other bytes are unchanged.
- R8: An erase whose selected sectors are all protected stays busy for `PROT_ERASE_CYCLES` cycles and changes no byte.
- R9: A suspend request during an erase releases `ready_n` on the next cycle and freezes the erase count. Reads in selected sectors then return `{1'b1, t, 6'b0}`. After a resume, the erase finishes after a total of `ERASE_CYCLES` busy cycles.
- R10: A program started during erase suspend follows R2 and R3, then returns to the suspended state.
- R11: The following starts are ignored: a program start during a running program, an erase, or a suspended program; an erase start outside the idle state; and an erase start with an all-zero select mask.
- R12: Every read strobe yields `rd_valid` high with its data exactly one cycle later; `rd_valid` is low otherwise.
- R13: The toggle stub `t` is 0 after reset and inverts after every read that returns a status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | One-cycle program start pulse |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | 8 | Byte to program |
| erase_start | input | 1 | One-cycle erase start pulse |
| erase_sel | input | 2**SECT_W | Sectors selected for erasure |
| sect_prot | input | 2**SECT_W | Per-sector protect mask, sampled at start |
| suspend_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Status byte or array data |
| ready_n | output | 1 | Low while an operation runs |

## Verification
A read result arrives at the port one clock after its strobe. `ready_n` falls one clock after an accepted start pulse and rises after exactly the configured number of busy cycles, so a run of N busy cycles shows as N consecutive low samples. The bench drives every input on the falling edge and samples on the next falling edge, which places each sample one register stage after its stimulus. It counts low samples of `ready_n` back to back, with no other activity in between, and compares the total with the parameter. Expected bytes come from a byte model of the array and a model of the toggle bit, both kept in the bench.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

    typedef enum logic [2:0] {
        MD_READ,
        MD_PROG,
        MD_ERASE,
        MD_SUSP,
        MD_SUSP_PROG
    } pe_mode_e;

    typedef enum logic [1:0] {
        RS_ARRAY,
        RS_PSTAT,
        RS_ESTAT,
        RS_TAIL
    } rd_src_e;

    localparam int BYTE_W = 8;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic poll, input logic tg);
        return {poll, tg, 6'b0};
    endfunction

    function automatic logic [BYTE_W-1:0] tail_byte(input logic [BYTE_W-1:0] arr, input logic tg);
        return {arr[BYTE_W-1], tg, 6'b0};
    endfunction

    function automatic logic is_busy(input pe_mode_e m);
        return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SUSP_PROG);
    endfunction

endpackage

// File: rtl/pe_busy_timer.sv
module pe_busy_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic          live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            live_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val;
            live_q <= 1'b1;
        end else if (run && live_q) begin
            if (cnt_q == '0) begin
                live_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = live_q && run && (cnt_q == '0);
endmodule

// File: rtl/pe_flash_array.sv
module pe_flash_array #(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 ers_en,
    input  logic [(1<<SECT_W)-1:0] ers_mask,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data
);
    localparam int NSECT     = 1 << SECT_W;
    localparam int OFF_W     = ADDR_W - SECT_W;
    localparam int SEC_WORDS = 1 << OFF_W;

    logic [SECT_W-1:0] wr_sect;
    logic [OFF_W-1:0]  wr_off;
    logic [SECT_W-1:0] rd_sect;
    logic [OFF_W-1:0]  rd_off;
    logic [7:0]        sec_rd [NSECT];

    assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];
    assign wr_off  = wr_addr[OFF_W-1:0];
    assign rd_sect = rd_addr[ADDR_W-1 -: SECT_W];
    assign rd_off  = rd_addr[OFF_W-1:0];

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        logic [7:0] mem [SEC_WORDS];

        always_ff @(posedge clk) begin
            if (rst || (ers_en && ers_mask[g])) begin
                for (int i = 0; i < SEC_WORDS; i++) begin
                    mem[i] <= 8'hFF;
                end
            end else if (wr_en && (wr_sect == SECT_W'(g))) begin
                mem[wr_off] <= wr_data;
            end
        end

        assign sec_rd[g] = mem[rd_off];
    end

    assign rd_data = sec_rd[rd_sect];
endmodule

// File: rtl/pe_status_resp.sv
module pe_status_resp
    import pe_status_pkg::*;
#(
    parameter int ADDR_W            = 8,
    parameter int SECT_W            = 3,
    parameter int PROG_CYCLES       = 12,
    parameter int ERASE_CYCLES      = 40,
    parameter int PROT_PROG_CYCLES  = 200,
    parameter int PROT_ERASE_CYCLES = 20000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    prog_start,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [7:0]              prog_data,
    input  logic                    erase_start,
    input  logic [(1<<SECT_W)-1:0]  erase_sel,
    input  logic [(1<<SECT_W)-1:0]  sect_prot,
    input  logic                    suspend_req,
    input  logic                    resume_req,
    input  logic                    rd_stb,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    ready_n
);
    localparam int NSECT = 1 << SECT_W;
    localparam int MAX_P = imax(PROG_CYCLES, PROT_PROG_CYCLES);
    localparam int MAX_E = imax(ERASE_CYCLES, PROT_ERASE_CYCLES);
    localparam int CW_P  = $clog2(MAX_P + 1);
    localparam int CW_E  = $clog2(MAX_E + 1);

    pe_mode_e            mode, mode_nx;
    logic [ADDR_W-1:0]   p_addr_q;
    logic [7:0]          p_data_q;
    logic                p_prot_q;
    logic [NSECT-1:0]    e_sel_q;
    logic [NSECT-1:0]    e_eff_q;
    logic                tail_q;
    logic                tail_prog_q;
    logic                tog_q;
    logic                rd_valid_q;
    logic [7:0]          rd_data_q;

    // command acceptance
    logic             prog_go, erase_go;
    logic             p_prot_now, e_allprot_now;
    logic [NSECT-1:0] e_eff_now;

    assign p_prot_now    = sect_prot[prog_addr[ADDR_W-1 -: SECT_W]];
    assign e_eff_now     = erase_sel & ~sect_prot;
    assign e_allprot_now = (e_eff_now == '0);
    assign prog_go  = prog_start && ((mode == MD_READ) || (mode == MD_SUSP));
    assign erase_go = erase_start && !prog_start && (mode == MD_READ) && (erase_sel != '0);

    // busy timers
    logic            p_done, e_done;
    logic [CW_P-1:0] p_load_val;
    logic [CW_E-1:0] e_load_val;

    assign p_load_val = p_prot_now    ? CW_P'(PROT_PROG_CYCLES - 1)  : CW_P'(PROG_CYCLES - 1);
    assign e_load_val = e_allprot_now ? CW_E'(PROT_ERASE_CYCLES - 1) : CW_E'(ERASE_CYCLES - 1);

    pe_busy_timer #(.CW(CW_P)) u_prog_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (prog_go),
        .load_val (p_load_val),
        .run      ((mode == MD_PROG) || (mode == MD_SUSP_PROG)),
        .done     (p_done)
    );

    pe_busy_timer #(.CW(CW_E)) u_erase_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (erase_go),
        .load_val (e_load_val),
        .run      (mode == MD_ERASE),
        .done     (e_done)
    );

    // array
    logic       arr_wr_en;
    logic [7:0] arr_rd;

    assign arr_wr_en = p_done && !p_prot_q;

    pe_flash_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (arr_wr_en),
        .wr_addr  (p_addr_q),
        .wr_data  (p_data_q),
        .ers_en   (e_done),
        .ers_mask (e_eff_q),
        .rd_addr  (rd_addr),
        .rd_data  (arr_rd)
    );

    // mode sequencing
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MD_READ: begin
                if (prog_go)       mode_nx = MD_PROG;
                else if (erase_go) mode_nx = MD_ERASE;
            end
            MD_PROG: begin
                if (p_done) mode_nx = MD_READ;
            end
            MD_ERASE: begin
                if (e_done)           mode_nx = MD_READ;
                else if (suspend_req) mode_nx = MD_SUSP;
            end
            MD_SUSP: begin
                if (prog_go)         mode_nx = MD_SUSP_PROG;
                else if (resume_req) mode_nx = MD_ERASE;
            end
            MD_SUSP_PROG: begin
                if (p_done) mode_nx = MD_SUSP;
            end
            default: mode_nx = MD_READ;
        endcase
    end

    // read source selection
    logic [SECT_W-1:0] rd_sect;
    logic              hit_p, hit_e, hit_t;
    rd_src_e           src;
    logic [7:0]        rd_byte;

    assign rd_sect = rd_addr[ADDR_W-1 -: SECT_W];
    assign hit_p = ((mode == MD_PROG) || (mode == MD_SUSP_PROG)) && (rd_addr == p_addr_q);
    assign hit_e = ((mode == MD_ERASE) || (mode == MD_SUSP) || (mode == MD_SUSP_PROG))
                   && e_sel_q[rd_sect];
    assign hit_t = tail_q && (tail_prog_q ? (rd_addr == p_addr_q) : e_sel_q[rd_sect]);

    always_comb begin
        if (hit_p)      src = RS_PSTAT;
        else if (hit_e) src = RS_ESTAT;
        else if (hit_t) src = RS_TAIL;
        else            src = RS_ARRAY;
    end

    always_comb begin
        unique case (src)
            RS_PSTAT: rd_byte = status_byte(~p_data_q[7], tog_q);
            RS_ESTAT: rd_byte = status_byte(mode != MD_ERASE, tog_q);
            RS_TAIL:  rd_byte = tail_byte(arr_rd, tog_q);
            default:  rd_byte = arr_rd;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MD_READ;
            p_addr_q    <= '0;
            p_data_q    <= '0;
            p_prot_q    <= 1'b0;
            e_sel_q     <= '0;
            e_eff_q     <= '0;
            tail_q      <= 1'b0;
            tail_prog_q <= 1'b0;
            tog_q       <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            mode       <= mode_nx;
            rd_valid_q <= rd_stb;
            if (rd_stb) begin
                rd_data_q <= rd_byte;
                if ((src == RS_PSTAT) || (src == RS_ESTAT)) begin
                    tog_q <= ~tog_q;
                end
            end
            if (prog_go) begin
                p_addr_q <= prog_addr;
                p_data_q <= prog_data;
                p_prot_q <= p_prot_now;
            end
            if (erase_go) begin
                e_sel_q <= erase_sel;
                e_eff_q <= e_eff_now;
            end
            if (prog_go || erase_go) begin
                tail_q <= 1'b0;
            end else if (p_done) begin
                tail_q      <= 1'b1;
                tail_prog_q <= 1'b1;
            end else if (e_done) begin
                tail_q      <= 1'b1;
                tail_prog_q <= 1'b0;
            end else if (rd_stb && (src == RS_TAIL)) begin
                tail_q <= 1'b0;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign ready_n  = !is_busy(mode);
endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk
    import pe_status_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NSECT  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic              rd_valid,
    input logic              ready_n,
    input logic              prog_start,
    input logic              erase_start,
    input logic [NSECT-1:0]  erase_sel,
    input logic              suspend_req,
    input logic              resume_req,
    input pe_mode_e          mode,
    input logic              e_done,
    input logic [ADDR_W-1:0] p_addr_q
);
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ready_n);

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);

    a_r12_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_n) |-> $past(prog_start || erase_start || resume_req));

    a_r9_suspend_releases: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ERASE && suspend_req && !e_done) |=> ready_n);

    a_r11_busy_keeps_target: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_PROG && prog_start) |=> $stable(p_addr_q));

    a_r11_empty_erase_ignored: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_READ && erase_start && !prog_start && erase_sel == '0) |=> ready_n);
endmodule

bind pe_status_resp pe_status_chk #(.ADDR_W(ADDR_W), .NSECT(1 << SECT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_stb      (rd_stb),
    .rd_valid    (rd_valid),
    .ready_n     (ready_n),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .erase_sel   (erase_sel),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .mode        (mode),
    .e_done      (e_done),
    .p_addr_q    (p_addr_q)
);

// File: tb/tb_pe_status_resp.sv
`timescale 1ns/1ps
module tb_pe_status_resp;
    localparam int AW  = 8;
    localparam int SW  = 3;
    localparam int PC  = 12;
    localparam int EC  = 40;
    localparam int PPC = 200;
    localparam int PEC = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_start = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [7:0]    prog_data = '0;
    logic          erase_start = 1'b0;
    logic [7:0]    erase_sel = '0;
    logic [7:0]    sect_prot = '0;
    logic          suspend_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          ready_n;

    pe_status_resp #(
        .ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
        .PROT_PROG_CYCLES(PPC), .PROT_ERASE_CYCLES(PEC)
    ) dut (
        .clk(clk), .rst(rst), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start), .erase_sel(erase_sel),
        .sect_prot(sect_prot), .suspend_req(suspend_req), .resume_req(resume_req),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .ready_n(ready_n)
    );

    always #2.5 clk = ~clk;

    int   checks = 0;
    int   fails  = 0;
    bit   done_flag = 0;
    logic tog_m = 1'b0;
    logic [7:0] mem_m [256];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R12 rd_valid", rd_valid, 1);
        d = rd_data;
    endtask

    task automatic rd_arr(input logic [7:0] a, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, mem_m[a]);
    endtask

    task automatic rd_stat(input logic [7:0] a, input logic poll, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, {poll, tog_m, 6'b0});
        tog_m = ~tog_m;
    endtask

    task automatic rd_tail(input logic [7:0] a, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, {mem_m[a][7], tog_m, 6'b0});
        rd_arr(a, req);
    endtask

    task automatic start_prog(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        prog_start = 1'b1;
        prog_addr  = a;
        prog_data  = d;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic start_erase(input logic [7:0] sel, input logic [7:0] prot);
        @(negedge clk);
        erase_start = 1'b1;
        erase_sel   = sel;
        sect_prot   = prot;
        @(negedge clk);
        erase_start = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready_n && n < 30000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic model_erase(input logic [7:0] eff);
        for (int i = 0; i < 256; i++) begin
            if (eff[i >> 5]) mem_m[i] = 8'hFF;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, n1, n2;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready_n", ready_n, 1);
        chk("R1 rd_valid", rd_valid, 0);
        for (int i = 0; i < 256; i++) rd_arr(8'(i), "R1 erased array");
        @(negedge clk);
        chk("R12 rd_valid idle", rd_valid, 0);

        // R2 program busy length and result
        start_prog(8'h10, 8'hA5);
        chk("R2 ready_n low", ready_n, 0);
        wait_ready(n);
        chk("R2 program busy cycles", n, PC);
        mem_m[8'h10] = 8'hA5;
        rd_tail(8'h10, "R5 program tail");

        // R3/R4/R13 status during program, R11 ignored starts
        start_prog(8'h05, 8'h3C);
        rd_stat(8'h05, 1'b1, "R3 program status");
        rd_stat(8'h05, 1'b1, "R13 toggle second read");
        rd_arr(8'h06, "R4 other address");
        @(negedge clk);
        erase_start = 1'b1; erase_sel = 8'h01;
        @(negedge clk);
        erase_start = 1'b0;
        prog_start = 1'b1; prog_addr = 8'h20; prog_data = 8'h00;
        @(negedge clk);
        prog_start = 1'b0;
        wait_ready(n);
        mem_m[8'h05] = 8'h3C;
        @(negedge clk);
        chk("R11 no restart after program", ready_n, 1);
        rd_tail(8'h05, "R5 tail bit7 zero");
        rd_arr(8'h20, "R11 ignored program");
        rd_arr(8'h00, "R11 ignored erase");

        // R6 protected program
        start_prog(8'h45, 8'h00);
        sect_prot = 8'h04;
        @(negedge clk);
        sect_prot = 8'h00;
        @(negedge clk);
        // program was started with sect_prot=0 above; redo with protection held
        wait_ready(n);
        mem_m[8'h45] = 8'h00;
        rd_tail(8'h45, "R2 second program");
        sect_prot = 8'h04;
        start_prog(8'h46, 8'h7F);
        wait_ready(n);
        chk("R6 protected busy cycles", n, PPC);
        rd_tail(8'h46, "R6 array unchanged");
        sect_prot = 8'h04;
        start_prog(8'h47, 8'h7F);
        rd_stat(8'h47, 1'b1, "R6 protected status");
        wait_ready(n);
        rd_tail(8'h47, "R6 array unchanged 2");
        sect_prot = 8'h00;

        // R7 erase status and result
        start_prog(8'h21, 8'h12); wait_ready(n); mem_m[8'h21] = 8'h12; rd_tail(8'h21, "R2 prep");
        start_prog(8'h61, 8'h34); wait_ready(n); mem_m[8'h61] = 8'h34; rd_tail(8'h61, "R2 prep");
        start_prog(8'h81, 8'h5A); wait_ready(n); mem_m[8'h81] = 8'h5A; rd_tail(8'h81, "R2 prep");
        start_erase(8'h0A, 8'h08);
        wait_ready(n);
        chk("R7 erase busy cycles", n, EC);
        model_erase(8'h02);
        rd_tail(8'h21, "R5 erase tail");
        start_erase(8'h04, 8'h00);
        rd_stat(8'h4F, 1'b0, "R7 erase status");
        rd_arr(8'h05, "R4 read outside erase");
        rd_stat(8'h40, 1'b0, "R13 erase status toggle");
        wait_ready(n);
        model_erase(8'h04);
        rd_tail(8'h45, "R5 erase tail 2");
        for (int i = 0; i < 256; i++) rd_arr(8'(i), "R7 array after erase");

        // R8 all selected sectors protected
        start_erase(8'h30, 8'h30);
        wait_ready(n);
        chk("R8 protected erase busy", n, PEC);
        rd_tail(8'h81, "R8 array unchanged");
        rd_arr(8'hA0, "R8 array unchanged 2");

        // R9/R10 suspend, program in suspend, resume
        start_prog(8'hC3, 8'h11); wait_ready(n); mem_m[8'hC3] = 8'h11; rd_tail(8'hC3, "R2 prep");
        sect_prot = 8'h00;
        start_erase(8'h40, 8'h00);
        n1 = 0;
        repeat (9) begin
            n1++;
            @(negedge clk);
        end
        suspend_req = 1'b1;
        n1++;
        @(negedge clk);
        suspend_req = 1'b0;
        chk("R9 ready after suspend", ready_n, 1);
        rd_stat(8'hC3, 1'b1, "R9 suspend status");
        rd_arr(8'h05, "R9 read outside");
        repeat (20) @(negedge clk);
        chk("R9 stays suspended", ready_n, 1);
        start_prog(8'h07, 8'h80);
        chk("R10 busy in suspend program", ready_n, 0);
        rd_stat(8'h07, 1'b0, "R10 program status");
        rd_stat(8'hC0, 1'b1, "R9 erase sector during program");
        wait_ready(n);
        mem_m[8'h07] = 8'h80;
        chk("R10 back to suspend", ready_n, 1);
        rd_tail(8'h07, "R10 tail");
        rd_stat(8'hC3, 1'b1, "R10 still suspended");
        @(negedge clk);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        wait_ready(n2);
        chk("R9 total erase busy", n1 + n2, EC);
        model_erase(8'h40);
        rd_tail(8'hC3, "R9 erase after resume");

        // R11 empty erase mask
        start_erase(8'h00, 8'h00);
        chk("R11 empty mask ignored", ready_n, 1);
        for (int i = 0; i < 256; i += 17) rd_arr(8'(i), "R11 final array");

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule